// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Collector

This block gathers ten interrupt causes into two byte-wide register banks and drives one shared interrupt request line. The first bank collects a timer overflow strobe, falling edges on two external pins, and a keyboard scan tick that the block generates itself every 4 ms. The second bank collects serial-bus events: suspend, setup received, OUT endpoint 0 done, and IN endpoints 0, 1 and 2 done. Every cause requests the same vector, so software reads both flag registers to see which cause fired.

Each bank has three registers on a small byte bus. The status register is read-only and shows the latched flags. The acknowledge register is write-only, and a 1 written to a bit clears that flag. The mask register can be read and written, and sets which latched flags reach the request line. Hardware is the only thing that can set a flag. A flag stays latched whether or not it is enabled, until software acknowledges it. The external pins pass through a two-flop synchronizer before the falling edges are detected. The request output is a registered level.

Top module: `dual_bank_irq`

## Requirements
- R1: First bank: status register at address 0, acknowledge at address 1, mask at address 2. Bit 0 is the timer strobe, bit 1 is external pin 0, bit 2 is external pin 1 and bit 3 is the keyboard tick. Bits 7..4 always read 0 and are never stored.
- R2: Second bank: status register at address 3, acknowledge at address 4, mask at address 5. Bit 0 is IN endpoint 0, bit 1 is OUT endpoint 0, bit 2 is IN endpoint 1, bit 3 is IN endpoint 2, bit 6 is setup and bit 7 is suspend. Bits 5..4 always read 0.
- R3: Only hardware events set flags. A write to a status address (0 or 3) changes nothing.
- R4: Writing 1 to an acknowledge bit clears that flag on the next clock edge. Writing 0 to an acknowledge bit leaves the flag as it is.
- R5: A flag latches even when its mask bit is 0.
- R6: An external pin sets its flag on a falling edge, seen after a two-flop synchronizer. A low level sampled at edge n sets the flag at edge n+2, when the sample before it was high. A rising edge sets nothing.
- R7: The keyboard tick sets bit 3 of the first bank at every TICK_CYCLES-th rising edge after reset is released, first at edge TICK_CYCLES.
- R8: After reset, all status and mask registers read 00h and irq is 0.
- R9: irq is 1 in the cycle after an edge where some flag and its mask bit were both 1 in the same bank. Otherwise it is 0.
- R10: If a hardware event and a 1 to the matching acknowledge bit arrive at the same edge, the flag ends up set.
- R11: Reads of the acknowledge addresses (1, 4) and of addresses 6 and 7 return 00h.
- R12: A mask register reads back the last value written to it, with the unused bits of that bank forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational, no side effects) |
| ext_pin | input | 2 | Asynchronous external interrupt pins, idle high |
| tmr_ovf | input | 1 | Timer overflow strobe, one cycle |
| ep_in_done | input | 3 | IN endpoint 0..2 transfer done strobes |
| ep_out_done | input | 1 | OUT endpoint 0 transfer done strobe |
| setup_done | input | 1 | Setup token done strobe |
| susp_det | input | 1 | Suspend detected strobe |
| irq | output | 1 | Registered shared interrupt request |

## Verification
A wrong flag shows up on bus_rdata in the same cycle its address is selected. It also shows up on irq one edge later, as long as that bit is enabled. A synchronizer or edge detector that is one flop short or one flop long moves the pin flag by a cycle. The per-cycle comparison reports this on the first clock where the two differ. An off-by-one in the tick counter is seen at edge TICK_CYCLES. Every later period adds one more cycle of drift, so a single period exposes it. A mask bit that is stored wrongly shows up as irq asserted or missing in the cycle after the matching flag appears.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_BANK = 2;
    localparam int N_PIN  = 2;
    localparam int N_IN_EP = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Register addresses: bank k uses base 3*k (status, ack, mask)
    localparam addr_t A_STAT = 3'd0;
    localparam addr_t A_ACK  = 3'd1;
    localparam addr_t A_MASK = 3'd2;
    localparam addr_t B_STAT = 3'd3;
    localparam addr_t B_ACK  = 3'd4;
    localparam addr_t B_MASK = 3'd5;

    localparam byte_t BANK_A_VALID = 8'h0F;
    localparam byte_t BANK_B_VALID = 8'hCF;

    // Bit positions, bank A
    localparam int BA_TMR  = 0;
    localparam int BA_PIN0 = 1;
    localparam int BA_PIN1 = 2;
    localparam int BA_TICK = 3;
    // Bit positions, bank B
    localparam int BB_IN0  = 0;
    localparam int BB_OUT0 = 1;
    localparam int BB_IN1  = 2;
    localparam int BB_IN2  = 3;
    localparam int BB_SETUP = 6;
    localparam int BB_SUSP  = 7;
endpackage

// File: rtl/dbi_pin_edge.sv
module dbi_pin_edge #(
    parameter int N_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_async,
    output logic [N_PIN-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < N_PIN; g++) begin : g_pin
            logic meta_q, sync_q, prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    sync_q <= 1'b1;
                    prev_q <= 1'b1;
                end else begin
                    meta_q <= pin_async[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign fall[g] = prev_q & ~sync_q;
        end
    endgenerate
endmodule

// File: rtl/dbi_tick.sv
module dbi_tick #(
    parameter int TICK_CYCLES = 24000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dbi_flag_bank.sv
module dbi_flag_bank
    import dbi_pkg::*;
#(
    parameter byte_t VALID = 8'hFF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t set_vec,
    input  byte_t ack_vec,
    input  logic  mask_we,
    input  byte_t mask_wdata,
    output byte_t flags,
    output byte_t mask,
    output logic  req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            // a new event beats a simultaneous acknowledge
            flags <= ((flags & ~ack_vec) | set_vec) & VALID;
            if (mask_we)
                mask <= mask_wdata & VALID;
        end
    end

    assign req = |(flags & mask);
endmodule

// File: rtl/dual_bank_irq.sv
module dual_bank_irq
    import dbi_pkg::*;
#(
    parameter int TICK_CYCLES = 24000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [2:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic [1:0]   ext_pin,
    input  logic         tmr_ovf,
    input  logic [2:0]   ep_in_done,
    input  logic         ep_out_done,
    input  logic         setup_done,
    input  logic         susp_det,
    output logic         irq
);
    localparam byte_t VALID_TBL [N_BANK] = '{BANK_A_VALID, BANK_B_VALID};

    logic [N_PIN-1:0] pin_fall;
    logic             kbd_tick;

    byte_t set_v  [N_BANK];
    byte_t ack_v  [N_BANK];
    byte_t flag_v [N_BANK];
    byte_t mask_v [N_BANK];
    logic  req_v  [N_BANK];

    dbi_pin_edge #(.N_PIN(N_PIN)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_pin),
        .fall      (pin_fall)
    );

    dbi_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (kbd_tick)
    );

    always_comb begin
        set_v[0] = '0;
        set_v[0][BA_TMR]  = tmr_ovf;
        set_v[0][BA_PIN0] = pin_fall[0];
        set_v[0][BA_PIN1] = pin_fall[1];
        set_v[0][BA_TICK] = kbd_tick;
        set_v[1] = '0;
        set_v[1][BB_IN0]   = ep_in_done[0];
        set_v[1][BB_OUT0]  = ep_out_done;
        set_v[1][BB_IN1]   = ep_in_done[1];
        set_v[1][BB_IN2]   = ep_in_done[2];
        set_v[1][BB_SETUP] = setup_done;
        set_v[1][BB_SUSP]  = susp_det;
    end

    genvar b;
    generate
        for (b = 0; b < N_BANK; b++) begin : g_bank
            localparam addr_t ACK_AD  = addr_t'(3 * b + 1);
            localparam addr_t MASK_AD = addr_t'(3 * b + 2);
            assign ack_v[b] = (bus_wr && bus_addr == ACK_AD) ? bus_wdata : '0;
            dbi_flag_bank #(.VALID(VALID_TBL[b])) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_vec    (set_v[b]),
                .ack_vec    (ack_v[b]),
                .mask_we    (bus_wr && bus_addr == MASK_AD),
                .mask_wdata (bus_wdata),
                .flags      (flag_v[b]),
                .mask       (mask_v[b]),
                .req        (req_v[b])
            );
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            A_STAT:  bus_rdata = flag_v[0];
            A_MASK:  bus_rdata = mask_v[0];
            B_STAT:  bus_rdata = flag_v[1];
            B_MASK:  bus_rdata = mask_v[1];
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= req_v[0] | req_v[1];
    end
endmodule

// File: rtl/dual_bank_irq_chk.sv
module dual_bank_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic [7:0] fa,
    input logic [7:0] fb,
    input logic [7:0] ma,
    input logic [7:0] mb,
    input logic [7:0] sa,
    input logic [7:0] sb,
    input logic [7:0] ca,
    input logic [7:0] cb
);
    // R3
    no_sw_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fa & ~$past(fa) & ~$past(sa)) == 8'h00));
    // R3
    no_sw_set_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fb & ~$past(fb) & ~$past(sb)) == 8'h00));
    // R4
    ack_clears_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fa & $past(ca) & ~$past(sa)) == 8'h00));
    // R4
    ack_clears_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fb & $past(cb) & ~$past(sb)) == 8'h00));
    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(fa) & ~$past(ca) & ~fa) | ($past(fb) & ~$past(cb) & ~fb)) == 8'h00));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~fa & $past(sa)) | (~fb & $past(sb))) == 8'h00));
    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|((fa & ma) | (fb & mb))) |=> irq);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|((fa & ma) | (fb & mb))) |=> !irq);
    // R1
    unused_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fa | ma) & 8'hF0) == 8'h00);
    // R2
    unused_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb | mb) & 8'h30) == 8'h00);
endmodule

bind dual_bank_irq dual_bank_irq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .fa    (flag_v[0]),
    .fb    (flag_v[1]),
    .ma    (mask_v[0]),
    .mb    (mask_v[1]),
    .sa    (set_v[0]),
    .sb    (set_v[1]),
    .ca    (ack_v[0]),
    .cb    (ack_v[1])
);

// File: tb/sim_dual_bank_irq.sv
`timescale 1ns/1ps
module sim_dual_bank_irq;
    localparam int TICK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] ext_pin = 2'b11;
    logic       tmr_ovf = 1'b0;
    logic [2:0] ep_in_done = 3'b000;
    logic       ep_out_done = 1'b0;
    logic       setup_done = 1'b0;
    logic       susp_det = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_bank_irq #(.TICK_CYCLES(TICK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .tmr_ovf(tmr_ovf), .ep_in_done(ep_in_done), .ep_out_done(ep_out_done),
        .setup_done(setup_done), .susp_det(susp_det), .irq(irq)
    );

    // Behavioural reference model
    int       ecount;
    bit [7:0] mf [2];
    bit [7:0] me [2];
    bit       m_irq;
    bit [2:0] hist [2];

    always @(posedge clk or negedge rst_n) begin
        bit [7:0] s0, s1, c0, c1;
        bit       nirq;
        if (!rst_n) begin
            ecount = 0;
            mf[0] = 0; mf[1] = 0; me[0] = 0; me[1] = 0;
            m_irq = 0;
            hist[0] = 3'b111; hist[1] = 3'b111;
        end else begin
            ecount++;
            nirq = |((mf[0] & me[0]) | (mf[1] & me[1]));
            s0 = 0; s1 = 0; c0 = 0; c1 = 0;
            s0[0] = tmr_ovf;
            s0[1] = hist[0][0] & ~hist[0][1];
            s0[2] = hist[1][0] & ~hist[1][1];
            s0[3] = (ecount % TICK) == 0;
            for (int i = 0; i < 2; i++) hist[i] = {ext_pin[i], hist[i][2:1]};
            s1[0] = ep_in_done[0]; s1[1] = ep_out_done; s1[2] = ep_in_done[1];
            s1[3] = ep_in_done[2]; s1[6] = setup_done; s1[7] = susp_det;
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: c0 = bus_wdata;
                    3'd4: c1 = bus_wdata;
                    3'd2: me[0] = bus_wdata & 8'h0F;
                    3'd5: me[1] = bus_wdata & 8'hCF;
                    default: ;
                endcase
            end
            mf[0] = (mf[0] & ~c0) | s0;
            mf[1] = (mf[1] & ~c1) | s1;
            m_irq = nirq;
        end
    end

    function automatic bit [7:0] model_rd(input bit [2:0] a);
        case (a)
            3'd0: return mf[0];
            3'd2: return me[0];
            3'd3: return mf[1];
            3'd5: return me[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 irq vs model", int'(irq), int'(m_irq));
            check("R1 R2 rdata vs model", int'(bus_rdata), int'(model_rd(bus_addr)));
        end
    end

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        @(negedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input bit [2:0] a, output bit [7:0] d);
        @(negedge clk); #2;
        bus_addr = a;
        #5 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        bit [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state, R11 ack reads
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R8 R11 reset read", v, 0);
        end
        check("R8 irq after reset", irq, 0);
        bus_addr = 3'd0;
        // R7 tick timing
        while (ecount != TICK - 1) @(negedge clk);
        check("R7 tick not yet", bus_rdata[3], 0);
        @(negedge clk);
        check("R7 tick at period", bus_rdata[3], 1);
        // R4 ack with 0 has no effect, ack with 1 clears
        wr(3'd1, 8'h00);
        rd(3'd0, v);
        check("R4 zero ack keeps flag", v[3], 1);
        wr(3'd1, 8'h08);
        rd(3'd0, v);
        check("R4 ack clears tick flag", v[3], 0);
        // R6 pin 0 falling edge
        @(negedge clk); #2 ext_pin[0] = 1'b0;
        idle(5);
        rd(3'd0, v);
        check("R6 pin0 fall sets bit1", v & 8'h07, 8'h02);
        wr(3'd1, 8'h02);
        @(negedge clk); #2 ext_pin[0] = 1'b1;
        idle(5);
        rd(3'd0, v);
        check("R6 rising edge ignored", v & 8'h07, 8'h00);
        @(negedge clk); #2 ext_pin[1] = 1'b0;
        idle(5);
        rd(3'd0, v);
        check("R6 pin1 fall sets bit2", v & 8'h07, 8'h04);
        // R5 latched with mask 0, R9 no irq
        check("R5 R9 no irq while masked", irq, 0);
        // R12 mask write/read, R9 irq follows
        wr(3'd2, 8'h04);
        idle(2);
        check("R9 irq after enable", irq, 1);
        rd(3'd2, v);
        check("R12 mask A readback", v, 8'h04);
        wr(3'd2, 8'hF3);
        rd(3'd2, v);
        check("R12 R1 mask A unused bits", v, 8'h03);
        idle(2);
        check("R9 irq drops when masked", irq, 0);
        // R3 write to status ignored
        wr(3'd0, 8'hFF);
        rd(3'd0, v);
        check("R3 status write ignored", v & 8'h07, 8'h04);
        wr(3'd1, 8'h07);
        wr(3'd2, 8'h00);
        // R2 second bank mapping
        @(negedge clk); #2 ep_in_done = 3'b001;
        @(negedge clk); #2 ep_in_done = 3'b000; ep_out_done = 1'b1;
        @(negedge clk); #2 ep_out_done = 1'b0; ep_in_done = 3'b010;
        @(negedge clk); #2 ep_in_done = 3'b100;
        @(negedge clk); #2 ep_in_done = 3'b000; setup_done = 1'b1;
        @(negedge clk); #2 setup_done = 1'b0; susp_det = 1'b1;
        @(negedge clk); #2 susp_det = 1'b0;
        rd(3'd3, v);
        check("R2 bank B all flags", v, 8'hCF);
        check("R5 bank B latched while masked", irq, 0);
        wr(3'd5, 8'hFF);
        rd(3'd5, v);
        check("R12 R2 mask B readback", v, 8'hCF);
        idle(1);
        check("R9 irq from bank B", irq, 1);
        wr(3'd4, 8'h0F);
        rd(3'd3, v);
        check("R4 bank B partial ack", v, 8'hC0);
        // R10 event and ack at the same edge
        @(negedge clk); #2;
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01; ep_in_done = 3'b001;
        @(negedge clk); #2;
        bus_wr = 1'b0; ep_in_done = 3'b000;
        rd(3'd3, v);
        check("R10 set wins over ack", v & 8'h01, 8'h01);
        wr(3'd4, 8'hFF);
        rd(3'd3, v);
        check("R4 bank B full ack", v, 8'h00);
        idle(2);
        check("R9 irq clears after ack", irq, 0);
        // R11 ack and spare addresses read zero
        rd(3'd4, v); check("R11 ack B reads zero", v, 0);
        rd(3'd1, v); check("R11 ack A reads zero", v, 0);
        rd(3'd6, v); check("R11 addr6 reads zero", v, 0);
        rd(3'd7, v); check("R11 addr7 reads zero", v, 0);
        // R1 timer strobe, R7 tick continues, R9 via bank A
        wr(3'd2, 8'h01);
        @(negedge clk); #2 tmr_ovf = 1'b1;
        @(negedge clk); #2 tmr_ovf = 1'b0;
        rd(3'd0, v);
        check("R1 timer bit0", v & 8'h07, 8'h01);
        idle(1);
        check("R9 irq from timer", irq, 1);
        idle(2 * TICK);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule